// File: doc/BRIEF.md
# Four-Phase Byte-Bus Register Slave

This block sits on the programmable-logic side of an eight-bit parallel link to a host microcontroller. The host frames each operation with a start pulse, pushes a six-byte request one byte at a time, and then pulls an eight-byte reply. Every byte crosses the link with a four-phase handshake: the host owns handshake-1 and the slave owns handshake-2. All host lines are asynchronous to the slave clock, so they pass through synchronizer chains, and every decision is taken on the synchronized copies.

The request holds a command byte, a register address byte and a 32-bit operand, with the operand sent low byte first. The reply holds a 32-bit result followed by a 32-bit status, each also low byte first. Command 0x00 reads a register and command 0x01 writes one. Address 0 is served inside the block from a constant identity word. Addresses 1 up to the last populated address go out on a one-cycle strobe interface to the register file behind the slave. When no start pulse has been seen, a raised handshake-1 still gets a handshake-2 answer, so the host can test the link without opening a transaction.

The controller has nine states. IDLE goes to PROBE when handshake-1 rises, and PROBE returns to IDLE when it falls. RX_WAIT captures a byte and moves to RX_HELD when handshake-1 rises with the select line at write. RX_HELD returns to RX_WAIT when handshake-1 falls, or goes to EXEC after the sixth byte. EXEC issues the access and moves to LATCH, which stores the reply and moves to TX_PRES. TX_PRES moves to TX_HS once the select line reads. TX_HS moves to TX_REL on a rising handshake-1. TX_REL goes back to TX_PRES on a falling handshake-1, or to IDLE after the eighth byte. Two transitions apply from every state: a synchronized start rising edge goes to RX_WAIT, and a low synchronized host reset goes to IDLE.

Top module: `hsbus_slave`

## Requirements
- R1: When `rst_n` or the synchronized `host_rst_n` is low, the slave returns to idle with `hs2`, `ack` and `bus_oe` low. This also cancels a transaction part way through, and a complete transaction afterwards works normally.
- R2: A rising edge on the synchronized `host_start` starts a new request from its first byte, even in the middle of a frame. `ack` stays high from that edge until `host_hs1` falls after the eighth reply byte, and then it goes low.
- R3: In the request phase, `hs2` stays low until the host raises `host_hs1` with `host_rd_sel` = 0 (write). `hs2` then rises with the byte captured, and it falls only after `host_hs1` has fallen.
- R4: Request bytes are taken in this order: command, address, then operand bits 7:0, 15:8, 23:16, 31:24.
- R5: In the reply phase, `hs2` rises only while `host_rd_sel` = 1 (read), with the byte already on `bus_out`. `hs2` falls after `host_hs1` rises. The next byte follows only after `host_hs1` falls.
- R6: The reply is eight bytes: result bits 7:0 through 31:24, then status bits 7:0 through 31:24.
- R7: `bus_oe` is high only in the reply phase while `host_rd_sel` = 1. It is never high outside a transaction.
- R8: Without a start pulse, a raised `host_hs1` makes `hs2` rise while `ack` stays low, and `hs2` falls once `host_hs1` falls.
- R9: A read of address 0 returns the identity word with status 0. The identity word packs major revision in bits 3:0, minor revision in 7:4, PWM unit count in 11:8, encoder unit count in 15:12 and servo unit count in 19:16; the defaults give 0x00084421. It makes no register-file access.
- R10: For an address from 1 to LAST (4·4 + 4·5 + 8 + 2 = 46 by default), a read gives exactly one single-cycle `reg_rd` and replies with `reg_rdata` and `reg_status`. A write gives exactly one single-cycle `reg_wr` with `reg_addr` and `reg_wdata` and replies with result 0 and `reg_status`.
- R11: A command byte other than 0x00 or 0x01 replies with result 0 and status 1, and makes no strobe.
- R12: An address above LAST replies with result 0 and status 2. A write to address 0 replies with result 0 and status 3. Neither makes a strobe, and the register contents and the identity word are unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Local asynchronous active-low reset |
| host_rst_n | input | 1 | Host reset, active low, asynchronous |
| host_start | input | 1 | Host transaction start pulse, asynchronous |
| host_rd_sel | input | 1 | Direction select: 1 read (slave drives), 0 write |
| host_hs1 | input | 1 | Host handshake line |
| bus_in | input | 8 | Byte from the host |
| bus_out | output | 8 | Reply byte toward the host |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| hs2 | output | 1 | Slave handshake line |
| ack | output | 1 | High while a transaction is open |
| reg_addr | output | 8 | Register-file address |
| reg_wdata | output | 32 | Register-file write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |
| reg_status | input | 32 | Access status, valid the cycle after a strobe |

## Verification
The assertions assume the host obeys the four-phase protocol. A line changes only after the host has seen the other side respond. `host_start` is held for more than one slave clock and goes high before the first byte's handshake-1. `bus_in` and `host_rd_sel` are stable before `host_hs1` rises. The stimulus keeps these rules: it moves inputs only on the falling clock edge, waits for each `hs2` transition before the next step, and holds the start pulse for three cycles. The register model answers one cycle after each strobe, which is the latency the controller expects. Apart from the reset and restart cases, the stimulus never breaks off a frame.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

    localparam int REQ_BYTES = 6;
    localparam int RSP_BYTES = 8;

    localparam logic [7:0] CMD_READ  = 8'h00;
    localparam logic [7:0] CMD_WRITE = 8'h01;

    localparam logic [31:0] STS_OK        = 32'd0;
    localparam logic [31:0] STS_BAD_CMD   = 32'd1;
    localparam logic [31:0] STS_BAD_ADDR  = 32'd2;
    localparam logic [31:0] STS_READ_ONLY = 32'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE,
        ST_RX_WAIT,
        ST_RX_HELD,
        ST_EXEC,
        ST_LATCH,
        ST_TX_PRES,
        ST_TX_HS,
        ST_TX_REL
    } fsm_state_t;

    typedef enum logic [2:0] {
        ACC_SYS,
        ACC_RD,
        ACC_WR,
        ACC_BAD_CMD,
        ACC_BAD_ADDR,
        ACC_RO
    } acc_kind_t;

    function automatic logic [31:0] pack_sys_word(input int maj, input int mnr,
                                                  input int pwm, input int enc,
                                                  input int srv);
        return {12'h000, 4'(srv), 4'(enc), 4'(pwm), 4'(mnr), 4'(maj)};
    endfunction

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/hsbus_reg_access.sv
module hsbus_reg_access
    import hsbus_pkg::*;
#(
    parameter logic [7:0]  LAST_A   = 8'd46,
    parameter logic [31:0] SYS_WORD = 32'h0
) (
    input  logic        exec_i,
    input  logic [7:0]  cmd_i,
    input  logic [7:0]  addr_i,
    input  logic [31:0] reg_rdata_i,
    input  logic [31:0] reg_status_i,
    output logic        reg_rd_o,
    output logic        reg_wr_o,
    output logic [31:0] res_data_o,
    output logic [31:0] res_status_o
);

    acc_kind_t kind;

    always_comb begin
        if (cmd_i != CMD_READ && cmd_i != CMD_WRITE) begin
            kind = ACC_BAD_CMD;
        end else if (addr_i > LAST_A) begin
            kind = ACC_BAD_ADDR;
        end else if (addr_i == 8'd0) begin
            kind = (cmd_i == CMD_READ) ? ACC_SYS : ACC_RO;
        end else begin
            kind = (cmd_i == CMD_READ) ? ACC_RD : ACC_WR;
        end
    end

    assign reg_rd_o = exec_i && (kind == ACC_RD);
    assign reg_wr_o = exec_i && (kind == ACC_WR);

    always_comb begin
        res_data_o   = 32'd0;
        res_status_o = STS_OK;
        unique case (kind)
            ACC_SYS:      res_data_o   = SYS_WORD;
            ACC_RD: begin
                res_data_o   = reg_rdata_i;
                res_status_o = reg_status_i;
            end
            ACC_WR:       res_status_o = reg_status_i;
            ACC_BAD_CMD:  res_status_o = STS_BAD_CMD;
            ACC_BAD_ADDR: res_status_o = STS_BAD_ADDR;
            ACC_RO:       res_status_o = STS_READ_ONLY;
            default:      res_status_o = STS_BAD_CMD;
        endcase
    end

endmodule

// File: rtl/hsbus_frame_fsm.sv
module hsbus_frame_fsm
    import hsbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_s,
    input  logic        rd_s,
    input  logic        hs1_s,
    input  logic        hrst_s_n,
    input  logic [7:0]  bus_in,
    input  logic [31:0] res_data,
    input  logic [31:0] res_status,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    output logic        hs2,
    output logic        ack,
    output logic        exec_o,
    output logic [7:0]  req_cmd,
    output logic [7:0]  req_addr,
    output logic [31:0] req_wdata
);

    localparam int IDX_W = $clog2(RSP_BYTES);
    localparam logic [IDX_W-1:0] REQ_LAST = IDX_W'(REQ_BYTES - 1);
    localparam logic [IDX_W-1:0] RSP_LAST = IDX_W'(RSP_BYTES - 1);

    fsm_state_t       state, nstate;
    logic             start_q;
    logic             start_rise;
    logic [IDX_W-1:0] idx;
    logic [7:0]       req_byte [REQ_BYTES];
    logic [63:0]      reply;
    logic             capture_en;

    assign start_rise = start_s && !start_q;
    assign capture_en = hrst_s_n && !start_rise && (state == ST_RX_WAIT)
                        && hs1_s && !rd_s;

    // Next-state decision
    always_comb begin
        nstate = state;
        if (!hrst_s_n) begin
            nstate = ST_IDLE;
        end else if (start_rise) begin
            nstate = ST_RX_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:    if (hs1_s)           nstate = ST_PROBE;
                ST_PROBE:   if (!hs1_s)          nstate = ST_IDLE;
                ST_RX_WAIT: if (hs1_s && !rd_s)  nstate = ST_RX_HELD;
                ST_RX_HELD: if (!hs1_s)
                                nstate = (idx == REQ_LAST) ? ST_EXEC : ST_RX_WAIT;
                ST_EXEC:                         nstate = ST_LATCH;
                ST_LATCH:                        nstate = ST_TX_PRES;
                ST_TX_PRES: if (rd_s)            nstate = ST_TX_HS;
                ST_TX_HS:   if (hs1_s)           nstate = ST_TX_REL;
                ST_TX_REL:  if (!hs1_s)
                                nstate = (idx == RSP_LAST) ? ST_IDLE : ST_TX_PRES;
                default:                         nstate = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Byte index, edge history and reply store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            idx     <= '0;
            reply   <= '0;
        end else begin
            start_q <= start_s;
            if (!hrst_s_n || start_rise) begin
                idx <= '0;
            end else if (state == ST_RX_HELD && !hs1_s) begin
                idx <= (idx == REQ_LAST) ? '0 : idx + 1'b1;
            end else if (state == ST_TX_REL && !hs1_s) begin
                idx <= idx + 1'b1;
            end
            if (state == ST_LATCH) begin
                reply <= {res_status, res_data};
            end
        end
    end

    // One capture register per request byte
    for (genvar b = 0; b < REQ_BYTES; b++) begin : g_req
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   req_byte[b] <= 8'h00;
            else if (capture_en && idx == IDX_W'(b))      req_byte[b] <= bus_in;
        end
    end

    assign req_cmd   = req_byte[0];
    assign req_addr  = req_byte[1];
    assign req_wdata = {req_byte[5], req_byte[4], req_byte[3], req_byte[2]};
    assign bus_out   = reply[8*idx +: 8];

    // Output decode
    always_comb begin
        hs2    = 1'b0;
        ack    = 1'b1;
        bus_oe = 1'b0;
        exec_o = 1'b0;
        unique case (state)
            ST_IDLE:    ack = 1'b0;
            ST_PROBE: begin
                ack = 1'b0;
                hs2 = 1'b1;
            end
            ST_RX_WAIT: ;
            ST_RX_HELD: hs2 = 1'b1;
            ST_EXEC:    exec_o = 1'b1;
            ST_LATCH:   ;
            ST_TX_PRES: bus_oe = rd_s;
            ST_TX_HS: begin
                hs2    = 1'b1;
                bus_oe = rd_s;
            end
            ST_TX_REL:  bus_oe = rd_s;
            default:    ack = 1'b0;
        endcase
    end

    // R1
    hrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hrst_s_n |=> (!hs2 && !ack));

    // R2
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> (($past(state) == ST_TX_REL && $past(idx) == RSP_LAST)
                        || !$past(hrst_s_n)));

    // R3
    wr_hs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs2) && state != ST_TX_HS) |-> $past(hs1_s));

    // R5
    rd_hs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs2) && state == ST_TX_HS) |-> ($past(rd_s) && !$past(hs1_s)));

    // R7
    oe_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ack);

    // R8
    probe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE && !hs1_s && hrst_s_n && !start_rise) |=> !hs2);

endmodule

// File: rtl/hsbus_slave.sv
module hsbus_slave
    import hsbus_pkg::*;
#(
    parameter int MAJOR_REV         = 1,
    parameter int MINOR_REV         = 2,
    parameter int PWM_UNITS         = 4,
    parameter int PWM_REGS_PER_UNIT = 4,
    parameter int ENC_UNITS         = 4,
    parameter int ENC_REGS_PER_UNIT = 5,
    parameter int SERVO_UNITS       = 8,
    parameter int SERVO_SHARED_REGS = 2,
    parameter int SYNC_STAGES       = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_rst_n,
    input  logic        host_start,
    input  logic        host_rd_sel,
    input  logic        host_hs1,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    output logic        hs2,
    output logic        ack,
    output logic [7:0]  reg_addr,
    output logic [31:0] reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [31:0] reg_rdata,
    input  logic [31:0] reg_status
);

    localparam int LAST_ADDR = PWM_UNITS * PWM_REGS_PER_UNIT
                             + ENC_UNITS * ENC_REGS_PER_UNIT
                             + SERVO_UNITS + SERVO_SHARED_REGS;
    localparam logic [7:0]  LAST_A   = 8'(LAST_ADDR);
    localparam logic [31:0] SYS_WORD = pack_sys_word(MAJOR_REV, MINOR_REV,
                                                     PWM_UNITS, ENC_UNITS,
                                                     SERVO_UNITS);

    logic [3:0]  sync_q;
    logic        exec;
    logic [7:0]  req_cmd;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [31:0] res_data;
    logic [31:0] res_status;

    hsbus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({host_rst_n, host_hs1, host_rd_sel, host_start}),
        .q_o   (sync_q)
    );

    hsbus_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_s    (sync_q[0]),
        .rd_s       (sync_q[1]),
        .hs1_s      (sync_q[2]),
        .hrst_s_n   (sync_q[3]),
        .bus_in     (bus_in),
        .res_data   (res_data),
        .res_status (res_status),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .hs2        (hs2),
        .ack        (ack),
        .exec_o     (exec),
        .req_cmd    (req_cmd),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata)
    );

    hsbus_reg_access #(.LAST_A(LAST_A), .SYS_WORD(SYS_WORD)) u_acc (
        .exec_i       (exec),
        .cmd_i        (req_cmd),
        .addr_i       (req_addr),
        .reg_rdata_i  (reg_rdata),
        .reg_status_i (reg_status),
        .reg_rd_o     (reg_rd),
        .reg_wr_o     (reg_wr),
        .res_data_o   (res_data),
        .res_status_o (res_status)
    );

    assign reg_addr  = req_addr;
    assign reg_wdata = req_wdata;

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |=> !(reg_rd || reg_wr));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R12
    strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (reg_addr != 8'd0 && reg_addr <= LAST_A));

    // R11
    strobe_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (req_cmd == CMD_READ || req_cmd == CMD_WRITE));

endmodule

// File: tb/hsbus_slave_bench.sv
module hsbus_slave_bench;

    localparam int LAST = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rst_n = 1'b1;
    logic        host_start = 1'b0;
    logic        host_rd_sel = 1'b0;
    logic        host_hs1 = 1'b0;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe, hs2, ack, reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = 32'd0;
    logic [31:0] reg_status = 32'd0;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] mem [256];

    always #10 clk = ~clk;

    hsbus_slave u_hsbus_slave (
        .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n),
        .host_start(host_start), .host_rd_sel(host_rd_sel), .host_hs1(host_hs1),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .hs2(hs2), .ack(ack),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .reg_status(reg_status)
    );

    // Register model: answers one cycle after a strobe; address 7 reports 0x55
    always @(posedge clk) begin
        if (reg_wr) mem[reg_addr] <= reg_wdata;
        if (reg_rd || reg_wr) begin
            reg_rdata  <= reg_rd ? mem[reg_addr] : 32'd0;
            reg_status <= (reg_addr == 8'd7) ? 32'h55 : 32'h0;
            if (reg_rd) rd_cnt <= rd_cnt + 1;
            if (reg_wr) wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, a + 8'hC3};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_hs2(input logic v);
        while (hs2 !== v) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        host_start = 1'b1;
        tick(3);
        host_start = 1'b0;
        tick(2);
    endtask

    task automatic put_byte(input logic [7:0] b);
        bus_in = b;
        host_rd_sel = 1'b0;
        tick(1);
        host_hs1 = 1'b1;
        wait_hs2(1'b1);
        host_hs1 = 1'b0;
        wait_hs2(1'b0);
    endtask

    task automatic get_byte(output logic [7:0] b);
        host_rd_sel = 1'b1;
        wait_hs2(1'b1);
        b = bus_out;
        chk("R7 oe while presenting", {31'd0, bus_oe}, 32'd1);
        host_hs1 = 1'b1;
        wait_hs2(1'b0);
        host_hs1 = 1'b0;
    endtask

    task automatic run_txn(input logic [7:0] cmd, input logic [7:0] addr,
                           input logic [31:0] wd,
                           output logic [31:0] rdata, output logic [31:0] sts);
        logic [7:0] b;
        pulse_start();
        chk("R2 ack after start", {31'd0, ack}, 32'd1);
        put_byte(cmd);
        put_byte(addr);
        for (int k = 0; k < 4; k++) put_byte(wd[8*k +: 8]);
        tick(6);
        chk("R7 oe low with write select", {31'd0, bus_oe}, 32'd0);
        chk("R5 no hs2 with write select", {31'd0, hs2}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            get_byte(b);
            if (k < 4) rdata[8*k +: 8] = b;
            else       sts[8*(k-4) +: 8] = b;
        end
        host_rd_sel = 1'b0;
        tick(5);
        chk("R2 ack low after reply", {31'd0, ack}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd, st;
        int rc, wc;
        logic [7:0] bad_addr [3];
        logic [7:0] bad_cmd [3];
        bad_addr[0] = 8'(LAST + 1); bad_addr[1] = 8'd128; bad_addr[2] = 8'd255;
        bad_cmd[0] = 8'h02; bad_cmd[1] = 8'h80; bad_cmd[2] = 8'hFF;

        tick(5);
        // R1 reset state
        chk("R1 hs2 in reset", {31'd0, hs2}, 32'd0);
        chk("R1 ack in reset", {31'd0, ack}, 32'd0);
        chk("R1 oe in reset", {31'd0, bus_oe}, 32'd0);
        rst_n = 1'b1;
        tick(5);

        // R9 identity word, computed from the field layout
        run_txn(8'h00, 8'd0, 32'd0, rd, st);
        chk("R9 identity word", rd, 32'(1 | (2 << 4) | (4 << 8) | (4 << 12) | (8 << 16)));
        chk("R9 identity status", st, 32'd0);
        chk("R9 no strobe", 32'(rd_cnt + wr_cnt), 32'd0);

        // R4 R10 write sweep over the populated range
        for (int a = 1; a <= LAST; a++) begin
            wc = wr_cnt;
            run_txn(8'h01, 8'(a), pat(8'(a)), rd, st);
            chk("R10 write result", rd, 32'd0);
            chk("R10 write status", st, (a == 7) ? 32'h55 : 32'h0);
            chk("R10 one write strobe", 32'(wr_cnt - wc), 32'd1);
        end

        // R6 R10 read-back sweep
        for (int a = 1; a <= LAST; a++) begin
            rc = rd_cnt;
            run_txn(8'h00, 8'(a), 32'hDEAD_BEEF, rd, st);
            chk("R6 R4 read data", rd, pat(8'(a)));
            chk("R6 read status", st, (a == 7) ? 32'h55 : 32'h0);
            chk("R10 one read strobe", 32'(rd_cnt - rc), 32'd1);
        end

        // R12 out-of-range addresses
        for (int i = 0; i < 3; i++) begin
            rc = rd_cnt; wc = wr_cnt;
            run_txn(8'h01, bad_addr[i], 32'h1234_5678, rd, st);
            chk("R12 bad addr write status", st, 32'd2);
            chk("R12 bad addr write result", rd, 32'd0);
            run_txn(8'h00, bad_addr[i], 32'd0, rd, st);
            chk("R12 bad addr read status", st, 32'd2);
            chk("R12 bad addr no strobe", 32'(rd_cnt - rc + wr_cnt - wc), 32'd0);
        end
        run_txn(8'h00, 8'(LAST), 32'd0, rd, st);
        chk("R12 last register unchanged", rd, pat(8'(LAST)));

        // R12 write to the identity word
        wc = wr_cnt;
        run_txn(8'h01, 8'd0, 32'hFFFF_FFFF, rd, st);
        chk("R12 read-only status", st, 32'd3);
        chk("R12 read-only result", rd, 32'd0);
        chk("R12 read-only no strobe", 32'(wr_cnt - wc), 32'd0);
        run_txn(8'h00, 8'd0, 32'd0, rd, st);
        chk("R12 identity unchanged", rd, 32'h0008_4421);

        // R11 unknown commands
        for (int i = 0; i < 3; i++) begin
            rc = rd_cnt; wc = wr_cnt;
            run_txn(bad_cmd[i], 8'd5, 32'hAAAA_5555, rd, st);
            chk("R11 bad cmd status", st, 32'd1);
            chk("R11 bad cmd result", rd, 32'd0);
            chk("R11 bad cmd no strobe", 32'(rd_cnt - rc + wr_cnt - wc), 32'd0);
        end
        run_txn(8'h00, 8'd5, 32'd0, rd, st);
        chk("R11 register 5 untouched", rd, pat(8'd5));

        // R8 liveness probe without start
        host_hs1 = 1'b1;
        tick(5);
        chk("R8 probe hs2 high", {31'd0, hs2}, 32'd1);
        chk("R8 probe ack low", {31'd0, ack}, 32'd0);
        host_hs1 = 1'b0;
        tick(5);
        chk("R8 probe hs2 released", {31'd0, hs2}, 32'd0);

        // R3 then R1: hold a byte without handshake, then host reset mid-frame
        pulse_start();
        bus_in = 8'h01;
        tick(6);
        chk("R3 hs2 waits for hs1", {31'd0, hs2}, 32'd0);
        put_byte(8'h01);
        put_byte(8'd9);
        host_rst_n = 1'b0;
        tick(20);
        chk("R1 host reset hs2", {31'd0, hs2}, 32'd0);
        chk("R1 host reset ack", {31'd0, ack}, 32'd0);
        host_rst_n = 1'b1;
        tick(5);
        run_txn(8'h00, 8'd9, 32'd0, rd, st);
        chk("R1 recovery read", rd, pat(8'd9));

        // R2 restart: a start edge in mid-request begins again at byte 0
        pulse_start();
        put_byte(8'h01);
        put_byte(8'd3);
        put_byte(8'h77);
        run_txn(8'h01, 8'd12, 32'hCAFE_F00D, rd, st);
        chk("R2 restart write status", st, 32'd0);
        run_txn(8'h00, 8'd12, 32'd0, rd, st);
        chk("R2 restart written value", rd, 32'hCAFE_F00D);
        run_txn(8'h00, 8'd3, 32'd0, rd, st);
        chk("R2 aborted frame left reg 3", rd, pat(8'd3));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule